// File: doc/BRIEF.md
# Memory Effective Address Generator

This block forms the 32-bit effective address of a load or store in a processor whose memory is one flat 4 GiB space. Decode hands it a mode select and the operand fields already pulled apart. These are a 12-bit short offset, a base register value, an index register value, a scale code, and the extra 32-bit word that some instruction forms carry. The block adds the parts the mode calls for. Every sum wraps modulo 2^32.

It is one registered pipeline stage. A request presented with `in_valid` gives a result one clock later with `out_valid`. The block also reports whether the selected mode consumes the extra 32-bit word, so that fetch can skip over it. It flags any scale code outside the legal set of 1, 2, 4, 8 and 16.

Mode codes used throughout: 0 short absolute, 1 long absolute, 2 register-indirect, 3 base plus short offset, 4 base plus long offset, 5 base plus scaled index, 6 scaled index plus extra word, 7 base plus scaled index plus extra word.

Top module: `mem_ea_gen`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the next outputs are `out_valid`=0, `addr`=0, `need_ext`=0 and `bad_scale`=0.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge, so a request gives a result exactly one cycle later.
- R3: Mode 0 yields the 12-bit `short_off` zero-extended to 32 bits.
- R4: Mode 1 yields `ext_word` unchanged, and mode 2 yields `base` unchanged.
- R5: Mode 3 yields `base` + zero-extended `short_off`, and mode 4 yields `base` + `ext_word`.
- R6: Mode 5 yields `base` + `index` × 2^`scale_code`.
- R7: Mode 6 yields `index` × 2^`scale_code` + `ext_word`, and `base` has no effect.
- R8: Mode 7 yields `base` + `index` × 2^`scale_code` + `ext_word`.
- R9: All sums, and the scaled index itself, wrap modulo 2^32.
- R10: `scale_code` values 0 to 4 select factors 1, 2, 4, 8 and 16. In modes 5 to 7, a code of 5, 6 or 7 sets `bad_scale` to 1 and `addr` to 0. In modes 0 to 4, `scale_code` has no effect and `bad_scale` is 0.
- R11: `need_ext` is 1 for modes 1, 4, 6 and 7 and 0 for modes 0, 2, 3 and 5.
- R12: A cycle with `in_valid` low leaves `addr`, `need_ext` and `bad_scale` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request valid |
| mode | input | 3 | Addressing mode code 0..7 |
| short_off | input | 12 | Short offset, zero-extended |
| ext_word | input | 32 | Extra 32-bit word: long offset or displacement |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale_code | input | 3 | Index shift count; 0..4 legal |
| out_valid | output | 1 | Result valid |
| addr | output | 32 | Effective address |
| need_ext | output | 1 | Mode consumes the extra word |
| bad_scale | output | 1 | Illegal scale code in an index mode |

## Verification
On every cycle, the assertions check the one-cycle valid latency, that the outputs clear under reset, and that the outputs hold while no request arrives. They also check the extra-word flag against the mode, the illegal-scale response, and the pass-through modes. The directed scenarios are needed to show the sums of the offset and index modes for chosen operands. They also cover wraparound past 2^32, every legal scale factor, and the fact that the scale field or the base is ignored in modes that do not use it.

// File: rtl/ea_pkg.sv
// Package: shared types for the effective address generator.
// Assumes: mode codes fixed at 3 bits; the code values are part of the contract.
package ea_pkg;

    typedef enum logic [2:0] {
        EA_ABS_SHORT  = 3'd0,
        EA_ABS_LONG   = 3'd1,
        EA_REG_IND    = 3'd2,
        EA_BASE_SHORT = 3'd3,
        EA_BASE_LONG  = 3'd4,
        EA_BASE_IDX   = 3'd5,
        EA_IDX_EXT    = 3'd6,
        EA_FULL       = 3'd7
    } ea_mode_e;

    // Which terms enter the sum for a given mode.
    typedef struct packed {
        logic use_base;
        logic use_index;
        logic use_short;
        logic use_ext;
    } ea_terms_t;

endpackage

// File: rtl/ea_mode_decode.sv
// Module: ea_mode_decode
// Turns a mode code into the set of terms that enter the address sum.
// Assumes: all eight codes are legal; purely combinational.
module ea_mode_decode
    import ea_pkg::*;
(
    input  logic [2:0] mode,
    output ea_terms_t  terms
);

    // Mode to term-select table.
    always_comb begin
        terms = '0;
        unique case (ea_mode_e'(mode))
            EA_ABS_SHORT:  terms.use_short = 1'b1;
            EA_ABS_LONG:   terms.use_ext   = 1'b1;
            EA_REG_IND:    terms.use_base  = 1'b1;
            EA_BASE_SHORT: begin
                terms.use_base  = 1'b1;
                terms.use_short = 1'b1;
            end
            EA_BASE_LONG:  begin
                terms.use_base = 1'b1;
                terms.use_ext  = 1'b1;
            end
            EA_BASE_IDX:   begin
                terms.use_base  = 1'b1;
                terms.use_index = 1'b1;
            end
            EA_IDX_EXT:    begin
                terms.use_index = 1'b1;
                terms.use_ext   = 1'b1;
            end
            EA_FULL:       begin
                terms.use_base  = 1'b1;
                terms.use_index = 1'b1;
                terms.use_ext   = 1'b1;
            end
            default:       terms = '0;
        endcase
    end

endmodule

// File: rtl/ea_scaler.sv
// Module: ea_scaler
// Shifts the index left by the scale code (factor 2^code) and flags codes
// beyond the largest legal shift.
// Assumes: MAX_SHIFT < 2^SCW; shifted bits beyond AW are discarded (wrap).
module ea_scaler #(
    parameter int AW        = 32,
    parameter int SCW       = 3,
    parameter int MAX_SHIFT = 4
) (
    input  logic [AW-1:0]  index,
    input  logic [SCW-1:0] scale_code,
    output logic [AW-1:0]  scaled,
    output logic           illegal
);

    localparam int NCAND = MAX_SHIFT + 1;

    logic [AW-1:0] cand [NCAND];

    // One pre-shifted candidate per legal scale factor.
    for (genvar s = 0; s < NCAND; s++) begin : g_shift
        assign cand[s] = index << s;
    end

    // Pick the candidate or report an out-of-range code.
    always_comb begin
        scaled  = '0;
        illegal = (int'(scale_code) > MAX_SHIFT);
        for (int s = 0; s < NCAND; s++) begin
            if (int'(scale_code) == s) scaled = cand[s];
        end
    end

endmodule

// File: rtl/ea_adder.sv
// Module: ea_adder
// Three-operand modulo-2^AW adder with per-term gating.
// Assumes: short offset is zero-extended; carry out of AW bits is dropped.
module ea_adder
    import ea_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 12
) (
    input  ea_terms_t       terms,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   scaled,
    input  logic [OFFW-1:0] short_off,
    input  logic [AW-1:0]   ext_word,
    output logic [AW-1:0]   sum
);

    localparam int PADW = AW - OFFW;

    logic [AW-1:0] t_base;
    logic [AW-1:0] t_idx;
    logic [AW-1:0] t_off;

    // Gate each operand by its select and add modulo 2^AW.
    always_comb begin
        t_base = terms.use_base  ? base   : '0;
        t_idx  = terms.use_index ? scaled : '0;
        if (terms.use_short)
            t_off = {{PADW{1'b0}}, short_off};
        else if (terms.use_ext)
            t_off = ext_word;
        else
            t_off = '0;
        sum = t_base + t_idx + t_off;
    end

endmodule

// File: rtl/mem_ea_gen.sv
// Module: mem_ea_gen (top)
// Registered effective address stage: decode mode, scale index, sum terms,
// capture result one cycle after in_valid.
// Assumes: synchronous active-low reset; outputs hold when no request arrives.
module mem_ea_gen
    import ea_pkg::*;
#(
    parameter int AW        = 32,
    parameter int OFFW      = 12,
    parameter int SCW       = 3,
    parameter int MAX_SHIFT = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      mode,
    input  logic [OFFW-1:0] short_off,
    input  logic [AW-1:0]   ext_word,
    input  logic [AW-1:0]   base,
    input  logic [AW-1:0]   index,
    input  logic [SCW-1:0]  scale_code,
    output logic            out_valid,
    output logic [AW-1:0]   addr,
    output logic            need_ext,
    output logic            bad_scale
);

    ea_terms_t     terms;
    logic [AW-1:0] scaled;
    logic          sc_illegal;
    logic [AW-1:0] sum;
    logic          bad_now;

    ea_mode_decode u_dec (
        .mode  (mode),
        .terms (terms)
    );

    ea_scaler #(.AW(AW), .SCW(SCW), .MAX_SHIFT(MAX_SHIFT)) u_scl (
        .index      (index),
        .scale_code (scale_code),
        .scaled     (scaled),
        .illegal    (sc_illegal)
    );

    ea_adder #(.AW(AW), .OFFW(OFFW)) u_add (
        .terms     (terms),
        .base      (base),
        .scaled    (scaled),
        .short_off (short_off),
        .ext_word  (ext_word),
        .sum       (sum)
    );

    // Scale errors only matter when the index enters the sum.
    assign bad_now = terms.use_index & sc_illegal;

    // Pipeline register: valid every cycle, payload only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            addr      <= '0;
            need_ext  <= 1'b0;
            bad_scale <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                addr      <= bad_now ? '0 : sum;
                need_ext  <= terms.use_ext;
                bad_scale <= bad_now;
            end
        end
    end

endmodule

// File: rtl/ea_checker.sv
// Module: ea_checker
// Temporal properties of mem_ea_gen, attached by bind.
// Assumes: default 32-bit address, 12-bit offset, 3-bit scale code.
module ea_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [2:0]  mode,
    input logic [31:0] ext_word,
    input logic [31:0] base,
    input logic [2:0]  scale_code,
    input logic        out_valid,
    input logic [31:0] addr,
    input logic        need_ext,
    input logic        bad_scale
);

    // R1: reset clears every output.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && addr == '0 && !need_ext && !bad_scale));

    // R2: valid out follows valid in by one cycle.
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: pass-through modes.
    p_long_abs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd1) |=> addr == $past(ext_word));
    p_reg_ind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode == 3'd2) |=> addr == $past(base));

    // R10: illegal scale in an index mode zeroes the address.
    p_bad_scale_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode >= 3'd5 && scale_code > 3'd4) |=> (bad_scale && addr == '0));
    p_no_bad_scale_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mode < 3'd5) |=> !bad_scale);

    // R11: extra word needed for modes 1, 4, 6, 7.
    p_need_ext_r11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> need_ext == ($past(mode) == 3'd1 || $past(mode) == 3'd4 ||
                                  $past(mode) == 3'd6 || $past(mode) == 3'd7));

    // R12: outputs hold without a request.
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(addr) && $stable(need_ext) && $stable(bad_scale)));

endmodule

bind mem_ea_gen ea_checker u_chk (.*);

// File: tb/sim_mem_ea_gen.sv
// Bench: directed scenarios for mem_ea_gen, one task per scenario.
module sim_mem_ea_gen;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic [11:0] short_off = '0;
    logic [31:0] ext_word = '0;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [2:0]  scale_code = '0;
    logic        out_valid;
    logic [31:0] addr;
    logic        need_ext;
    logic        bad_scale;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    mem_ea_gen u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run is a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one request, let it register, sample mid-cycle.
    task automatic issue(input logic [2:0] m, input logic [11:0] so, input logic [31:0] ew,
                         input logic [31:0] b, input logic [31:0] ix, input logic [2:0] sc);
        @(negedge clk);
        in_valid = 1'b1; mode = m; short_off = so; ext_word = ew;
        base = b; index = ix; scale_code = sc;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
        chk("R1 addr", addr, 32'd0);
        chk("R1 flags", {30'b0, need_ext, bad_scale}, 32'd0);
    endtask

    task automatic t_absolute();
        issue(3'd0, 12'hABC, 32'hFFFF_FFFF, 32'h1234_5678, 32'h5, 3'd7);
        chk("R2 out_valid", {31'b0, out_valid}, 32'd1);
        chk("R3 short abs zext", addr, 32'h0000_0ABC);
        chk("R10 scale ignored", {31'b0, bad_scale}, 32'd0);
        chk("R11 mode0 need_ext", {31'b0, need_ext}, 32'd0);
        issue(3'd1, 12'hFFF, 32'hDEAD_BEEF, 32'h1, 32'h1, 3'd0);
        chk("R4 long abs", addr, 32'hDEAD_BEEF);
        chk("R11 mode1 need_ext", {31'b0, need_ext}, 32'd1);
        issue(3'd2, 12'h123, 32'h7, 32'h8000_0010, 32'h3, 3'd6);
        chk("R4 reg indirect", addr, 32'h8000_0010);
        chk("R10 reg ind scale ignored", {31'b0, bad_scale}, 32'd0);
    endtask

    task automatic t_base_offset();
        issue(3'd3, 12'hFF0, 32'h0, 32'h0000_1000, 32'h0, 3'd0);
        chk("R5 base+short", addr, 32'h0000_1FF0);
        chk("R11 mode3 need_ext", {31'b0, need_ext}, 32'd0);
        issue(3'd4, 12'h0, 32'h0000_0100, 32'h4000_0000, 32'h0, 3'd0);
        chk("R5 base+long", addr, 32'h4000_0100);
        chk("R11 mode4 need_ext", {31'b0, need_ext}, 32'd1);
    endtask

    task automatic t_scaled();
        for (int s = 0; s < 5; s++) begin
            issue(3'd5, 12'h0, 32'h0, 32'h0000_1000, 32'h0000_0003, 3'(s));
            chk("R6/R10 base+idx scale", addr, 32'h0000_1000 + 32'd3 * (32'd1 << s));
        end
        chk("R11 mode5 need_ext", {31'b0, need_ext}, 32'd0);
        issue(3'd6, 12'h0, 32'h0000_0020, 32'hFFFF_0000, 32'h0000_0010, 3'd2);
        chk("R7 idx+ext no base", addr, 32'h0000_0060);
        chk("R11 mode6 need_ext", {31'b0, need_ext}, 32'd1);
        issue(3'd7, 12'h0, 32'h0000_0005, 32'h0000_0100, 32'h0000_0004, 3'd4);
        chk("R8 full", addr, 32'h0000_0145);
        chk("R11 mode7 need_ext", {31'b0, need_ext}, 32'd1);
    endtask

    task automatic t_wrap();
        issue(3'd4, 12'h0, 32'h0000_0020, 32'hFFFF_FFF0, 32'h0, 3'd0);
        chk("R9 wrap base+long", addr, 32'h0000_0010);
        issue(3'd5, 12'h0, 32'h0, 32'h0000_0001, 32'h9000_0001, 3'd4);
        chk("R9 wrap scaled index", addr, 32'h0000_0011);
    endtask

    task automatic t_bad_scale();
        for (int s = 5; s < 8; s++) begin
            issue(3'd7, 12'h0, 32'h10, 32'h100, 32'h1, 3'(s));
            chk("R10 bad_scale set", {31'b0, bad_scale}, 32'd1);
            chk("R10 addr zeroed", addr, 32'd0);
        end
        issue(3'd4, 12'h0, 32'h10, 32'h100, 32'h1, 3'd5);
        chk("R10 non-index clears bad_scale", {31'b0, bad_scale}, 32'd0);
        chk("R10 non-index addr", addr, 32'h110);
    endtask

    task automatic t_hold();
        issue(3'd3, 12'h00F, 32'h0, 32'h0000_2000, 32'h0, 3'd0);
        @(negedge clk);
        mode = 3'd7; base = 32'hFFFF_FFFF; index = 32'h7; scale_code = 3'd6; ext_word = 32'h9;
        @(posedge clk);
        @(negedge clk);
        chk("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
        chk("R12 addr held", addr, 32'h0000_200F);
        chk("R12 flags held", {30'b0, need_ext, bad_scale}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_absolute();
        t_base_offset();
        t_scaled();
        t_wrap();
        t_bad_scale();
        t_hold();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        t_reset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule